// File: doc/BRIEF.md
# Receive Descriptor Writeback Generator

This block takes the summary of one received frame and turns it into the status words that are written back for that frame. The summary holds the total byte count, the packet checksum, the protocol check flags, an error byte and a VLAN tag. The receive buffers all have one fixed size, set by a parameter. A frame longer than one buffer is spread over several buffers, and the block emits one 64-bit word for each buffer the frame fills.

Frames come in over a valid/ready handshake. The words leave over a second valid/ready handshake. A frame is accepted only while the block is idle. The words are then presented one at a time, and the block returns to idle once the word marked end-of-packet has been taken. Buffer addresses, data movement and descriptor fetching are handled elsewhere.

Top module: `rxwb_gen`

## Requirements
- R1: After reset `wb_valid` is 0 and `frm_ready` is 1. Each word is packed with the byte count in bits 15:0, the checksum in bits 31:16, the status byte in bits 39:32, the error byte in bits 47:40 and the VLAN tag in bits 63:48.
- R2: Every word except the last of a frame carries `BUF_BYTES` as its byte count. The last word carries the remainder of the frame length, or `BUF_BYTES` when the frame length is an exact multiple of the buffer size. The CRC bytes are part of the frame length.
- R3: Status bit 0 (done) is 1 in every word.
- R4: Status bit 1 (end-of-packet) is 1 only in the frame's last word. A frame produces exactly ceil(length / `BUF_BYTES`) words.
- R5: Status bits 3, 4, 5 and 6 carry the `frm_vlan`, `frm_udp`, `frm_tcp` and `frm_ip4` flags in every word of the frame. Status bits 2 and 7 are always 0.
- R6: The checksum field holds `frm_csum` in the first word of a frame and 0 in every later word.
- R7: The error byte and the VLAN tag are 0 in every word except the end-of-packet word, which carries `frm_err` and `frm_vtag`.
- R8: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid` stays 1 and `wb_word` does not change.
- R9: `frm_ready` is 0 from the acceptance of a frame until its end-of-packet word has been taken. A frame offered during that time is held off and is then accepted with its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame summary offered |
| frm_ready | output | 1 | Block idle; the summary is taken on a cycle with valid and ready both high |
| frm_len | input | 16 | Total frame byte count including CRC, nonzero |
| frm_csum | input | 16 | Packet checksum |
| frm_vtag | input | 16 | VLAN tag |
| frm_err | input | 8 | Error byte |
| frm_vlan | input | 1 | Frame had a VLAN header |
| frm_udp | input | 1 | UDP checksum was computed |
| frm_tcp | input | 1 | TCP checksum was computed |
| frm_ip4 | input | 1 | IPv4 header checksum was computed |
| wb_valid | output | 1 | Writeback word presented |
| wb_ready | input | 1 | Consumer takes the word |
| wb_word | output | 64 | Writeback word |

## Verification
The assertions assume that a frame is never offered with a length of zero. They also assume that the buffer size fits the 16-bit count field. The bench always uses lengths of at least one byte, well below the 16-bit limit, and keeps the default buffer size. The handshake assertions make no assumption about `wb_ready`. The bench drives `wb_ready` low for several cycles in mid-frame and offers a second frame while the first is still being drained, so the stall and hold-off rules are exercised.

// File: rtl/rxwb_gen.sv
module rxwb_gen #(
  parameter int unsigned BUF_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  output logic        frm_ready,
  input  logic [15:0] frm_len,
  input  logic [15:0] frm_csum,
  input  logic [15:0] frm_vtag,
  input  logic [7:0]  frm_err,
  input  logic        frm_vlan,
  input  logic        frm_udp,
  input  logic        frm_tcp,
  input  logic        frm_ip4,
  output logic        wb_valid,
  input  logic        wb_ready,
  output logic [63:0] wb_word
);
  localparam int unsigned CNT_W = 16;
  localparam logic [CNT_W-1:0] BUF_L = CNT_W'(BUF_BYTES);

  logic             busy, first;
  logic [CNT_W-1:0] rem;
  logic [15:0]      csum_q, vtag_q;
  logic [7:0]       err_q;
  logic [3:0]       flg_q;

  wire              last    = (rem <= BUF_L);
  wire [CNT_W-1:0]  cnt     = last ? rem : BUF_L;
  wire [7:0]        status  = {1'b0, flg_q, 1'b0, last, 1'b1};
  wire              take_in = frm_valid && !busy;
  wire              take_wb = busy && wb_ready;

  assign frm_ready = !busy;
  assign wb_valid  = busy;
  assign wb_word   = {last ? vtag_q : 16'h0, last ? err_q : 8'h0, status,
                      first ? csum_q : 16'h0, cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      first  <= 1'b0;
      rem    <= '0;
      csum_q <= '0;
      vtag_q <= '0;
      err_q  <= '0;
      flg_q  <= '0;
    end else if (take_in) begin
      busy   <= 1'b1;
      first  <= 1'b1;
      rem    <= frm_len;
      csum_q <= frm_csum;
      vtag_q <= frm_vtag;
      err_q  <= frm_err;
      flg_q  <= {frm_ip4, frm_tcp, frm_udp, frm_vlan};
    end else if (take_wb) begin
      first <= 1'b0;
      if (last) busy <= 1'b0;
      else      rem  <= rem - BUF_L;
    end
  end

  // input assumption: frames are never empty
  a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |-> (frm_len != 16'h0));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_word)));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !frm_ready);

  a_r4_more_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && !wb_word[33]) |=> wb_valid);

  a_r6_csum_later_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && !wb_word[33]) |=> (wb_word[31:16] == 16'h0));

  a_r3_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_word[32]);

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!wb_word[34] && !wb_word[39]));

  a_r9_idle_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && wb_word[33]) |=> frm_ready);
endmodule

// File: tb/sim_rxwb_gen.sv
`timescale 1ns/1ps
module sim_rxwb_gen;
  localparam int BUF = 256;

  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, wb_ready = 0;
  logic [15:0] frm_len = 0, frm_csum = 0, frm_vtag = 0;
  logic [7:0] frm_err = 0;
  logic frm_vlan = 0, frm_udp = 0, frm_tcp = 0, frm_ip4 = 0;
  logic frm_ready, wb_valid;
  logic [63:0] wb_word;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxwb_gen #(.BUF_BYTES(BUF)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_csum(frm_csum), .frm_vtag(frm_vtag), .frm_err(frm_err),
    .frm_vlan(frm_vlan), .frm_udp(frm_udp), .frm_tcp(frm_tcp), .frm_ip4(frm_ip4),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_word(wb_word));

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic present(int len, logic [15:0] cs, logic [15:0] vt, logic [7:0] er, logic [3:0] fl);
    frm_valid = 1; frm_len = 16'(len); frm_csum = cs; frm_vtag = vt; frm_err = er;
    {frm_ip4, frm_tcp, frm_udp, frm_vlan} = fl;
  endtask

  // check one presented word field by field; fl = {ip4,tcp,udp,vlan}
  task automatic chk_word(int len, int idx, logic [15:0] cs, logic [15:0] vt, logic [7:0] er, logic [3:0] fl);
    int n = (len + BUF - 1) / BUF;
    bit lst = (idx == n - 1);
    int l = lst ? len - idx * BUF : BUF;
    chk("R1 wb_valid", 64'(wb_valid), 64'd1);
    chk("R2 length", 64'(wb_word[15:0]), 64'(l));
    chk("R6 checksum", 64'(wb_word[31:16]), 64'(idx == 0 ? cs : 16'h0));
    chk("R3 done bit", 64'(wb_word[32]), 64'd1);
    chk("R4 eop bit", 64'(wb_word[33]), 64'(lst));
    chk("R5 flags and reserved", 64'(wb_word[39:32] & 8'hFC), 64'({1'b0, fl, 3'b000}));
    chk("R7 error byte", 64'(wb_word[47:40]), 64'(lst ? er : 8'h0));
    chk("R7 vlan tag", 64'(wb_word[63:48]), 64'(lst ? vt : 16'h0));
  endtask

  // called at a negedge with the first word presented; stall>0 holds ready low on word 'sidx'
  task automatic collect(int len, logic [15:0] cs, logic [15:0] vt, logic [7:0] er, logic [3:0] fl,
                         int stall, int sidx, bit expect_blocked);
    int n = (len + BUF - 1) / BUF;
    for (int i = 0; i < n; i++) begin
      chk_word(len, i, cs, vt, er, fl);
      if (expect_blocked) chk("R9 held off while busy", 64'(frm_ready), 64'd0);
      if (stall > 0 && i == sidx) begin
        logic [63:0] held = wb_word;
        for (int s = 0; s < stall; s++) begin
          wb_ready = 0;
          @(posedge clk); @(negedge clk);
          chk("R8 valid held", 64'(wb_valid), 64'd1);
          chk("R8 word stable", wb_word, held);
        end
      end
      wb_ready = 1;
      @(posedge clk); @(negedge clk);
      wb_ready = 0;
    end
    chk("R4 idle after eop", 64'(wb_valid), 64'd0);
    chk("R9 ready after eop", 64'(frm_ready), 64'd1);
  endtask

  task automatic run_frame(int len, logic [15:0] cs, logic [15:0] vt, logic [7:0] er, logic [3:0] fl,
                           int stall, int sidx);
    @(negedge clk);
    chk("R9 ready when idle", 64'(frm_ready), 64'd1);
    present(len, cs, vt, er, fl);
    @(posedge clk); @(negedge clk);
    frm_valid = 0;
    collect(len, cs, vt, er, fl, stall, sidx, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset wb_valid", 64'(wb_valid), 64'd0);
    chk("R1 reset frm_ready", 64'(frm_ready), 64'd1);
  endtask

  task automatic t_single;
    run_frame(60, 16'hBEEF, 16'h0123, 8'h00, 4'b0110, 0, 0);
    run_frame(1, 16'h1111, 16'h0FFF, 8'h81, 4'b1001, 0, 0);
  endtask

  task automatic t_exact;
    run_frame(BUF, 16'hA5A5, 16'h0042, 8'h04, 4'b1111, 0, 0);
    run_frame(2 * BUF, 16'h5A5A, 16'h0777, 8'h10, 4'b0001, 0, 0);
  endtask

  task automatic t_remainder;
    run_frame(2 * BUF + 88, 16'hC0DE, 16'h0ABC, 8'h22, 4'b1010, 0, 0);
    run_frame(BUF + 1, 16'h7E57, 16'h0DEF, 8'hFF, 4'b0100, 0, 0);
  endtask

  task automatic t_stall;
    run_frame(3 * BUF - 5, 16'h9999, 16'h0321, 8'h33, 4'b1100, 3, 0);
    run_frame(3 * BUF - 5, 16'h8888, 16'h0654, 8'h44, 4'b0011, 4, 2);
  endtask

  task automatic t_holdoff;
    @(negedge clk);
    present(2 * BUF + 10, 16'h1234, 16'h0AAA, 8'h55, 4'b0101);
    @(posedge clk); @(negedge clk);
    present(BUF + 7, 16'h4321, 16'h0BBB, 8'h66, 4'b1010);
    collect(2 * BUF + 10, 16'h1234, 16'h0AAA, 8'h55, 4'b0101, 2, 1, 1);
    @(posedge clk); @(negedge clk);
    frm_valid = 0;
    collect(BUF + 7, 16'h4321, 16'h0BBB, 8'h66, 4'b1010, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_single();
    t_exact();
    t_remainder();
    t_stall();
    t_holdoff();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule